// File: doc/BRIEF.md
# Interrupt Target Arbiter

This block is the decision core of a small platform interrupt controller. It takes a set of level-sensitive interrupt sources. Each source has its own priority register. Each context (a hart or privilege target) has a threshold and a packed set of enable bits. A gateway per source latches a pending request. Every cycle, and separately for each context, combinational selection finds the highest-priority source that is pending and enabled for that context. The context's interrupt line is high whenever that winner's priority is strictly above the context threshold.

Software reaches the block through a flat valid/address/data register port.

- **Claim:** a read of a context's claim word returns the winning source ID. It also clears that source's pending bit. The gateway then holds off new requests from that source until a completion arrives.
- **Completion:** a write of the source ID to the same word finishes the interrupt. It re-arms the gateway only if the ID is enabled for the writing context. Otherwise it is dropped.

Because selection never stops, a driver can mask a source by writing priority zero and leave its enable bit set. Completions for that source then keep working.

Top module: `irq_target_arb`

## Requirements
- R1: After reset all priorities, thresholds and enable bits are zero, every `irq_o` bit is low, and a claim read returns 0.
- R2: A source drives a context's line only if it is pending, its priority is nonzero, and its enable bit for that context is set.
- R3: `irq_o[c]` is high exactly when the winner's priority for context c is strictly greater than that context's threshold; a threshold of 0 passes any nonzero priority.
- R4: The winner is the candidate with the highest priority; between equal priorities the lowest source ID wins.
- R5: A priority write changes `irq_o` in the cycle right after the write edge, even for a source that is already pending.
- R6: A claim read returns, one edge later on `reg_rdata_o`, the winner ID if its priority exceeds the threshold and 0 otherwise. A nonzero claim clears that source's pending bit and blocks it until a completion.
- R7: A completion write carrying a source ID enabled for the writing context unblocks that source's gateway; a still-high source is pending again one edge later.
- R8: A completion whose ID is not enabled for the writing context has no effect: the source stays blocked.
- R9: A source at priority zero with its enable bit set is masked, but a completion for it is still accepted, and raising its priority later makes it visible at once.
- R10: Each source's priority register is separate; writing one leaves every other priority unchanged.
- R11: Register map (word addresses, data in the low bits):
  - priority of source s at s, with a 3-bit field;
  - enable word w of context c at 0x100 + c*ENW + w, where bit b enables source 32w+b;
  - threshold of context c at 0x200 + 2c, with a 3-bit field;
  - claim/complete of context c at 0x201 + 2c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Level interrupt requests; bit 0 unused |
| reg_valid_i | input | 1 | Register access this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, registered one edge after the read |
| irq_o | output | N_CTX | Interrupt line per context |

## Verification
The selection logic is driven with the following patterns:
- **Equal priorities on two sources:** separates lowest-ID tie-breaking from higher-priority-wins.
- **Threshold swept through the winner's priority:** exposes an off-by-one between "greater than" and "greater or equal".
- **Completions from a context that has the ID enabled and from one that does not:** distinguishes re-arm from silent drop.
- **Priority of an already-pending source lowered and raised, including to zero:** tells continuous re-evaluation apart from a value captured when the request arrived.

// File: rtl/ita_pkg.sv
package ita_pkg;
  localparam int PRIO_W   = 3;
  localparam int EN_BASE  = 'h100;
  localparam int CTX_BASE = 'h200;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/ita_gateway.sv
module ita_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic busy_o
);
  logic pend_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      if (complete_i) busy_q <= 1'b0;
      if (src_i && !pend_q && !busy_q) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  AST_PEND_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && busy_q)); // R6
  AST_CLAIM_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |-> pend_q); // R6
  AST_CLAIM_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (busy_q && !pend_q)); // R6
endmodule

// File: rtl/ita_select.sv
module ita_select
  import ita_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand_i,
  input  prio_t            prio_i [N_SRC],
  output logic [SRC_W-1:0] win_id_o,
  output prio_t            win_prio_o
);
  // strict compare keeps the lowest ID on ties; priority 0 never wins
  always_comb begin
    win_id_o   = '0;
    win_prio_o = '0;
    for (int i = 1; i < N_SRC; i++) begin
      if (cand_i[i] && prio_i[i] > win_prio_o) begin
        win_id_o   = SRC_W'(i);
        win_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_target_arb.sv
module irq_target_arb
  import ita_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CTX  = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_CTX-1:0]  irq_o
);
  localparam int SRC_W   = $clog2(N_SRC);
  localparam int ENW     = (N_SRC + DATA_W - 1) / DATA_W;
  localparam int EN_BITS = ENW * DATA_W;
  localparam int CTX_W   = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int EW_W    = (ENW > 1) ? $clog2(ENW) : 1;

  prio_t              prio_q [N_SRC];
  prio_t              thr_q  [N_CTX];
  logic [EN_BITS-1:0] en_q   [N_CTX];
  logic [N_SRC-1:0]   pend, busy, claim_vec, cmpl_vec;
  logic [SRC_W-1:0]   win_id   [N_CTX];
  prio_t              win_prio [N_CTX];
  logic [N_SRC-1:0]   cand     [N_CTX];

  // address decode
  logic [ADDR_W-1:0] en_off, ctx_off;
  logic              prio_hit, en_hit, ctx_hit, is_claim;
  logic [CTX_W-1:0]  en_ctx, ctx_idx;
  logic [EW_W-1:0]   en_word;
  logic              rd, wr, claim_rd, cmpl_wr, cmpl_ok, claim_live;
  logic [SRC_W-1:0]  cmpl_id;

  always_comb begin
    en_off   = reg_addr_i - ADDR_W'(EN_BASE);
    ctx_off  = reg_addr_i - ADDR_W'(CTX_BASE);
    prio_hit = reg_addr_i < ADDR_W'(N_SRC);
    en_hit   = reg_addr_i >= ADDR_W'(EN_BASE) && en_off < ADDR_W'(N_CTX * ENW);
    ctx_hit  = reg_addr_i >= ADDR_W'(CTX_BASE) && ctx_off < ADDR_W'(2 * N_CTX);
    is_claim = ctx_off[0];
    en_ctx   = CTX_W'(en_off / ADDR_W'(ENW));
    en_word  = EW_W'(en_off % ADDR_W'(ENW));
    ctx_idx  = CTX_W'(ctx_off >> 1);
    rd       = reg_valid_i && !reg_write_i;
    wr       = reg_valid_i && reg_write_i;
    claim_rd = rd && ctx_hit && is_claim;
    cmpl_wr  = wr && ctx_hit && is_claim;
    cmpl_id  = reg_wdata_i[SRC_W-1:0];
    cmpl_ok  = cmpl_wr && (reg_wdata_i < DATA_W'(N_SRC)) && en_q[ctx_idx][cmpl_id];
    claim_live = win_prio[ctx_idx] > thr_q[ctx_idx];
    claim_vec  = (claim_rd && claim_live) ? (N_SRC'(1) << win_id[ctx_idx]) : '0;
    cmpl_vec   = cmpl_ok ? (N_SRC'(1) << cmpl_id) : '0;
  end

  // gateways, source 0 reserved
  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;
  for (genvar s = 1; s < N_SRC; s++) begin : g_gw
    ita_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[s]),
      .claim_i    (claim_vec[s]),
      .complete_i (cmpl_vec[s]),
      .pend_o     (pend[s]),
      .busy_o     (busy[s])
    );
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    assign cand[c] = pend & en_q[c][N_SRC-1:0];
    ita_select #(.N_SRC(N_SRC)) u_sel (
      .cand_i     (cand[c]),
      .prio_i     (prio_q),
      .win_id_o   (win_id[c]),
      .win_prio_o (win_prio[c])
    );
    assign irq_o[c] = win_prio[c] > thr_q[c];

    AST_IRQ_NEEDS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (|cand[c])); // R2
  end

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        thr_q[c] <= '0;
        en_q[c]  <= '0;
      end
    end else if (wr) begin
      if (prio_hit && reg_addr_i != '0)
        prio_q[SRC_W'(reg_addr_i)] <= reg_wdata_i[PRIO_W-1:0];
      if (en_hit)
        en_q[en_ctx][en_word*DATA_W +: DATA_W] <= reg_wdata_i;
      if (ctx_hit && !is_claim)
        thr_q[ctx_idx] <= reg_wdata_i[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
    end else if (rd) begin
      if (prio_hit)
        reg_rdata_o <= DATA_W'(prio_q[SRC_W'(reg_addr_i)]);
      else if (en_hit)
        reg_rdata_o <= en_q[en_ctx][en_word*DATA_W +: DATA_W];
      else if (ctx_hit && !is_claim)
        reg_rdata_o <= DATA_W'(thr_q[ctx_idx]);
      else if (claim_rd && claim_live)
        reg_rdata_o <= DATA_W'(win_id[ctx_idx]);
      else
        reg_rdata_o <= '0;
    end
  end

  AST_DROP_CMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_wr && !cmpl_ok) |=> (busy == $past(busy))); // R8
  AST_CLAIM_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vec != '0) |=> ((busy & $past(claim_vec)) == $past(claim_vec))); // R6
  AST_CLAIM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_vec)); // R6
endmodule

// File: tb/irq_target_arb_bench.sv
`timescale 1ns/1ps
module irq_target_arb_bench;
  localparam int N_SRC = 16, N_CTX = 2, DW = 32, AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_SRC-1:0] src = '0;
  logic valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N_CTX-1:0] irq;

  always #2 clk = ~clk;

  irq_target_arb #(.N_SRC(N_SRC), .N_CTX(N_CTX), .DATA_W(DW), .ADDR_W(AW)) u_irq_target_arb (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_valid_i(valid), .reg_write_i(write),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    string       req;
    int          kind;   // 0 = irq_o, 1 = reg_rdata_o
    logic [31:0] val;
    int          due;
  } exp_t;

  exp_t q[$];
  int cyc = 0, vectors = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.kind == 1) ? rdata : 32'(irq);
      vectors++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL %s: %s actual=%0h expected=%0h", it.req,
                 (it.kind == 1) ? "rdata" : "irq", act, it.val);
      end
    end
  end

  task automatic push(input string req, input int kind, input logic [31:0] v, input int dly);
    q.push_back('{req, kind, v, cyc + dly});
  endtask

  task automatic bus(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; write = w; addr = a; wdata = d;
    @(posedge clk); #1;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    push("R1", 0, 0, 0);
    bus(0, 10'h005, 0); push("R1", 1, 0, 0);
    bus(0, 10'h201, 0); push("R1", 1, 0, 0);

    @(negedge clk); src = 16'h0028;               // sources 3 and 5 high
    bus(1, 10'h100, 32'h28);                      // ctx0 enables 3,5
    idle(2); push("R2", 0, 0, 0);                 // priorities still zero
    bus(1, 10'h003, 2); push("R2", 0, 2'b01, 0);
    bus(1, 10'h101, 32'h20); push("R2", 0, 2'b01, 0); // ctx1 enables 5 only
    bus(1, 10'h005, 2); push("R2", 0, 2'b11, 0);

    bus(1, 10'h200, 2); push("R3", 0, 2'b10, 0);  // thr equal to winner prio
    bus(0, 10'h201, 0); push("R6", 1, 0, 0);      // nothing above threshold
    bus(1, 10'h200, 1); push("R3", 0, 2'b11, 0);
    bus(1, 10'h200, 0);

    bus(0, 10'h201, 0); push("R4", 1, 3, 0);      // tie -> lowest ID
    push("R6", 0, 2'b11, 0);
    bus(0, 10'h201, 0); push("R6", 1, 5, 0);
    push("R6", 0, 2'b00, 0);
    idle(3); push("R6", 0, 2'b00, 0);             // blocked while busy

    bus(1, 10'h203, 3);                           // ctx1 lacks source 3
    idle(2); push("R8", 0, 2'b00, 0);
    bus(0, 10'h201, 0); push("R8", 1, 0, 0);

    bus(1, 10'h201, 3); push("R7", 0, 2'b00, 0); push("R7", 0, 2'b01, 1);
    idle(2);
    bus(1, 10'h203, 5); push("R7", 0, 2'b11, 1);
    idle(2);
    bus(1, 10'h005, 6);
    bus(0, 10'h201, 0); push("R4", 1, 5, 0);      // higher prio beats lower ID
    push("R6", 0, 2'b01, 0);
    bus(1, 10'h203, 5); idle(2); push("R7", 0, 2'b11, 0);

    bus(1, 10'h200, 3); push("R3", 0, 2'b11, 0);
    bus(1, 10'h005, 1); push("R5", 0, 2'b10, 0);  // pending source lowered

    bus(0, 10'h203, 0); push("R6", 1, 5, 0);
    push("R6", 0, 2'b00, 0);
    bus(1, 10'h005, 0);
    bus(1, 10'h203, 5);
    idle(2); push("R9", 0, 2'b00, 0);
    bus(1, 10'h005, 3); push("R9", 0, 2'b10, 0);

    bus(0, 10'h003, 0); push("R10", 1, 2, 0);
    bus(0, 10'h005, 0); push("R10", 1, 3, 0);
    bus(0, 10'h101, 0); push("R11", 1, 32'h20, 0);
    bus(0, 10'h200, 0); push("R11", 1, 3, 0);

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule